// File: doc/BRIEF.md
# Triggered byte-copy DMA channel

This block is one channel of direct memory access. It moves one byte per transaction from a source address to a destination address. The source can lie in the register/RAM data space, in program flash or in data EEPROM. The destination always lies in the data space. Each transaction has two phases on a simple request/grant memory bus: a read at the source pointer, then a write of the buffered byte at the destination pointer.

Two counters set how long a message is, one for the source and one for the destination. Each reloads from its own size register. A message ends when either counter reloads, so one start moves as many bytes as the smaller size. Stop bits decide whether a reload of one counter also ends the whole operation. Messages start from a software go bit, or from a hardware trigger pulse when the trigger enable is set. A hardware abort ends the operation at once. Four one-cycle interrupt pulses report:
- a source counter reload
- a destination counter reload
- an abort
- an overrun, which is a trigger that arrives while a message is still running

Software programs the channel through a write-only register port while the enable bit is low. It then sets the enable together with go, and optionally the trigger and abort enables.

Top module: `dma_chan`

## Requirements
- R1: After reset the following are all low: `busy_o`, `xfer_o`, `mem_req_o` and every interrupt output. The pointers and counters read zero.
- R2: A write through the register port at `cfg_addr_i` sets one register.
  - Address 0 is control: bit0 enable, bit1 go, bit2 hardware-trigger enable, bit3 abort enable.
  - Address 1 is mode: [1:0] source space select, [3:2] source address mode, [5:4] destination address mode, bit6 source stop, bit7 destination stop.
  - Address 2 is source start [15:0] and address 3 is source start [21:16].
  - Address 4 is destination start.
  - Address 5 is source size and address 6 is destination size.
  - While enable is low, `src_ptr_o`/`dst_ptr_o` follow the start registers and `src_cnt_o`/`dst_cnt_o` follow the size registers.
- R3: Each byte is moved in two phases.
  - First a read: `mem_req_o`=1 and `mem_we_o`=0 at the source pointer. This phase holds until `mem_gnt_i`, and `mem_rdata_i` is captured in that cycle.
  - Then a write: `mem_req_o`=1 and `mem_we_o`=1 of that byte at the destination pointer. This phase also holds until grant.
  - `xfer_o` is high from the cycle after the read grant until the write grant.
- R4: Source space select 00 drives `mem_space_o`=0 (data space), 01 drives 1 (flash), and both 10 and 11 drive 2 (EEPROM). Outside flash, `mem_addr_o`[21:16] is zero on a read. Writes always use space 0.
- R5: Address mode 01 steps the pointer +1 after each byte, 10 steps it -1, and 00 or 11 leave it unchanged. Source arithmetic wraps at 22 bits and destination arithmetic at 16 bits.
- R6: After each written byte, a counter at 1 reloads its size and its pointer reloads its start address. Otherwise the counter decrements. Any reload ends the message. `irq_src_o`/`irq_dst_o` pulse for one cycle, the cycle after the reloading write is granted. Sizes must be at least 1.
- R7: If a reloading counter has its stop bit set, the operation ends. Go, the trigger enable and the abort enable clear, and `busy_o` falls.
- R8: With no stop bits and the trigger enable clear, messages run back to back while go is set. Clearing go lets the current message finish and starts no further one.
- R9: With the trigger enable set, nothing moves until a `trig_i` pulse, and each pulse starts exactly one message.
- R10: A `trig_i` pulse while a message runs, with the trigger enable set, is dropped and gives an `irq_ovr_o` pulse.
- R11: An `abort_i` pulse while abort enable is set and the channel is armed or running does the following at once:
  - returns the channel to idle and clears go and the trigger enable;
  - discards the buffered byte without writing it and leaves pointers and counters untouched;
  - pulses `irq_abort_o` in the next cycle.
- R12: Clearing enable returns the channel to idle, with no request from the next cycle on. It also reloads the pointers from the start registers and the counters from the sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register index |
| cfg_wdata_i | input | 16 | Register write data |
| trig_i | input | 1 | Hardware start pulse |
| abort_i | input | 1 | Hardware abort pulse |
| mem_req_o | output | 1 | Bus request |
| mem_we_o | output | 1 | 1 write phase, 0 read phase |
| mem_space_o | output | 2 | 0 data space, 1 flash, 2 EEPROM |
| mem_addr_o | output | 22 | Bus address |
| mem_wdata_o | output | 8 | Byte being written |
| mem_rdata_i | input | 8 | Read data, valid with grant |
| mem_gnt_i | input | 1 | Bus grant for the current phase |
| src_ptr_o | output | 22 | Live source pointer |
| dst_ptr_o | output | 16 | Live destination pointer |
| src_cnt_o | output | 16 | Live source counter |
| dst_cnt_o | output | 16 | Live destination counter |
| busy_o | output | 1 | Armed or message running |
| xfer_o | output | 1 | Byte held between read and write |
| irq_src_o | output | 1 | Source counter reload pulse |
| irq_dst_o | output | 1 | Destination counter reload pulse |
| irq_abort_o | output | 1 | Abort pulse |
| irq_ovr_o | output | 1 | Overrun pulse |

## Verification
Faults in the pointer, counter and space logic do not stay hidden. A pointer that steps the wrong way, or a counter that reloads one byte early or late, writes the wrong address or data on the very next write grant. It also changes the number of writes and reload pulses before the stop. A wrong space decode or a missing upper-bit mask changes the byte that is read, and that byte appears on the bus one write phase later. A control bit that is not cleared on stop or abort shows as further bus requests within a few cycles. An abort that fails to drop the buffered byte shows as a write once the grant returns.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    AM_FIXED = 2'd0, AM_INC = 2'd1, AM_DEC = 2'd2, AM_RSVD = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2
  } xfer_state_e;

  typedef enum logic [1:0] {
    SP_DATA = 2'd0, SP_FLASH = 2'd1, SP_EEPROM = 2'd2
  } mem_space_e;

  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_MODE   = 1;
  localparam int unsigned REG_SRC_LO = 2;
  localparam int unsigned REG_SRC_HI = 3;
  localparam int unsigned REG_DST    = 4;
  localparam int unsigned REG_SRC_SZ = 5;
  localparam int unsigned REG_DST_SZ = 6;

  function automatic mem_space_e decode_space(input logic [1:0] sel);
    case (sel)
      2'd0:    return SP_DATA;
      2'd1:    return SP_FLASH;
      default: return SP_EEPROM;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned SRC_AW = 22,
  parameter int unsigned DST_AW = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CFG_AW = 3,
  parameter int unsigned CFG_DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic              stop_clr_i,
  input  logic              abort_clr_i,
  output logic              en_o,
  output logic              go_o,
  output logic              hw_en_o,
  output logic              abort_en_o,
  output logic [1:0]        space_sel_o,
  output addr_mode_e        src_mode_o,
  output addr_mode_e        dst_mode_o,
  output logic              src_stop_o,
  output logic              dst_stop_o,
  output logic [SRC_AW-1:0] src_start_o,
  output logic [DST_AW-1:0] dst_start_o,
  output logic [CNT_W-1:0]  src_size_o,
  output logic [CNT_W-1:0]  dst_size_o
);
  localparam int unsigned HI_W = SRC_AW - 16;

  logic [15:0]   src_lo_q;
  logic [HI_W-1:0] src_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= 1'b0; go_o <= 1'b0; hw_en_o <= 1'b0; abort_en_o <= 1'b0;
      space_sel_o <= '0; src_mode_o <= AM_FIXED; dst_mode_o <= AM_FIXED;
      src_stop_o <= 1'b0; dst_stop_o <= 1'b0;
      src_lo_q <= '0; src_hi_q <= '0; dst_start_o <= '0;
      src_size_o <= '0; dst_size_o <= '0;
    end else begin
      if (cfg_we_i) begin
        case (cfg_addr_i)
          CFG_AW'(REG_CTRL): begin
            en_o       <= cfg_wdata_i[0];
            go_o       <= cfg_wdata_i[1];
            hw_en_o    <= cfg_wdata_i[2];
            abort_en_o <= cfg_wdata_i[3];
          end
          CFG_AW'(REG_MODE): begin
            space_sel_o <= cfg_wdata_i[1:0];
            src_mode_o  <= addr_mode_e'(cfg_wdata_i[3:2]);
            dst_mode_o  <= addr_mode_e'(cfg_wdata_i[5:4]);
            src_stop_o  <= cfg_wdata_i[6];
            dst_stop_o  <= cfg_wdata_i[7];
          end
          CFG_AW'(REG_SRC_LO): src_lo_q    <= cfg_wdata_i[15:0];
          CFG_AW'(REG_SRC_HI): src_hi_q    <= cfg_wdata_i[HI_W-1:0];
          CFG_AW'(REG_DST):    dst_start_o <= cfg_wdata_i[DST_AW-1:0];
          CFG_AW'(REG_SRC_SZ): src_size_o  <= cfg_wdata_i[CNT_W-1:0];
          CFG_AW'(REG_DST_SZ): dst_size_o  <= cfg_wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end
      // hardware clears override a same-cycle software write
      if (stop_clr_i) begin
        go_o <= 1'b0; hw_en_o <= 1'b0; abort_en_o <= 1'b0;
      end
      if (abort_clr_i) begin
        go_o <= 1'b0; hw_en_o <= 1'b0;
      end
    end
  end

  assign src_start_o = {src_hi_q, src_lo_q};
endmodule

// File: rtl/dma_chan_side.sv
module dma_chan_side
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  addr_mode_e    mode_i,
  input  logic [AW-1:0] start_i,
  input  logic [CW-1:0] size_i,
  output logic [AW-1:0] ptr_o,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  assign wrap_o = (cnt_o == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      cnt_o <= '0;
    end else if (load_i || (step_i && wrap_o)) begin
      ptr_o <= start_i;
      cnt_o <= size_i;
    end else if (step_i) begin
      cnt_o <= cnt_o - CW'(1);
      case (mode_i)
        AM_INC:  ptr_o <= ptr_o + AW'(1);
        AM_DEC:  ptr_o <= ptr_o - AW'(1);
        default: ptr_o <= ptr_o;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              go_i,
  input  logic              hw_en_i,
  input  logic              abort_en_i,
  input  logic              src_stop_i,
  input  logic              dst_stop_i,
  input  logic              trig_i,
  input  logic              abort_i,
  input  logic              gnt_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              src_wrap_i,
  input  logic              dst_wrap_i,
  output xfer_state_e       state_o,
  output logic              abort_hit_o,
  output logic              step_o,
  output logic              stop_hit_o,
  output logic [DATA_W-1:0] buf_o,
  output logic              irq_src_o,
  output logic              irq_dst_o,
  output logic              irq_abort_o,
  output logic              irq_ovr_o
);
  xfer_state_e state_d;
  logic active, start, msg_end, ovr;

  assign active      = (state_o != ST_IDLE);
  assign abort_hit_o = en_i && abort_en_i && abort_i && (go_i || active);
  assign start       = en_i && go_i && (hw_en_i ? trig_i : 1'b1);
  assign step_o      = (state_o == ST_WR) && gnt_i && en_i && !abort_hit_o;
  assign msg_end     = step_o && (src_wrap_i || dst_wrap_i);
  assign stop_hit_o  = step_o && ((src_stop_i && src_wrap_i) || (dst_stop_i && dst_wrap_i));
  assign ovr         = en_i && hw_en_i && trig_i && active;

  always_comb begin
    state_d = state_o;
    if (!en_i || abort_hit_o) begin
      state_d = ST_IDLE;
    end else begin
      case (state_o)
        ST_IDLE: if (start) state_d = ST_RD;
        ST_RD:   if (gnt_i) state_d = ST_WR;
        ST_WR:   if (gnt_i) state_d = msg_end ? ST_IDLE : ST_RD;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o     <= ST_IDLE;
      buf_o       <= '0;
      irq_src_o   <= 1'b0;
      irq_dst_o   <= 1'b0;
      irq_abort_o <= 1'b0;
      irq_ovr_o   <= 1'b0;
    end else begin
      state_o <= state_d;
      if (state_o == ST_RD && gnt_i && en_i && !abort_hit_o) buf_o <= rdata_i;
      irq_src_o   <= step_o && src_wrap_i;
      irq_dst_o   <= step_o && dst_wrap_i;
      irq_abort_o <= abort_hit_o;
      irq_ovr_o   <= ovr;
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int unsigned SRC_AW = 22,
  parameter int unsigned DST_AW = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CFG_AW = 3,
  parameter int unsigned CFG_DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic              trig_i,
  input  logic              abort_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_space_o,
  output logic [SRC_AW-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_gnt_i,
  output logic [SRC_AW-1:0] src_ptr_o,
  output logic [DST_AW-1:0] dst_ptr_o,
  output logic [CNT_W-1:0]  src_cnt_o,
  output logic [CNT_W-1:0]  dst_cnt_o,
  output logic              busy_o,
  output logic              xfer_o,
  output logic              irq_src_o,
  output logic              irq_dst_o,
  output logic              irq_abort_o,
  output logic              irq_ovr_o
);
  localparam int unsigned HI_W  = SRC_AW - 16;
  localparam int unsigned PAD_W = SRC_AW - DST_AW;

  logic ctl_en, ctl_go, ctl_hw_en, ctl_abort_en, src_stop, dst_stop;
  logic [1:0] space_sel;
  addr_mode_e src_mode, dst_mode;
  logic [SRC_AW-1:0] src_start;
  logic [DST_AW-1:0] dst_start;
  logic [CNT_W-1:0]  src_size, dst_size;
  logic src_wrap, dst_wrap, step, stop_hit, abort_hit;
  xfer_state_e st;
  mem_space_e  src_space;

  dma_chan_regs #(
    .SRC_AW(SRC_AW), .DST_AW(DST_AW), .CNT_W(CNT_W), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
  ) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .stop_clr_i(stop_hit), .abort_clr_i(abort_hit),
    .en_o(ctl_en), .go_o(ctl_go), .hw_en_o(ctl_hw_en), .abort_en_o(ctl_abort_en),
    .space_sel_o(space_sel), .src_mode_o(src_mode), .dst_mode_o(dst_mode),
    .src_stop_o(src_stop), .dst_stop_o(dst_stop),
    .src_start_o(src_start), .dst_start_o(dst_start),
    .src_size_o(src_size), .dst_size_o(dst_size)
  );

  dma_chan_side #(.AW(SRC_AW), .CW(CNT_W)) u_src (
    .clk_i, .rst_ni, .load_i(!ctl_en), .step_i(step), .mode_i(src_mode),
    .start_i(src_start), .size_i(src_size),
    .ptr_o(src_ptr_o), .cnt_o(src_cnt_o), .wrap_o(src_wrap)
  );

  dma_chan_side #(.AW(DST_AW), .CW(CNT_W)) u_dst (
    .clk_i, .rst_ni, .load_i(!ctl_en), .step_i(step), .mode_i(dst_mode),
    .start_i(dst_start), .size_i(dst_size),
    .ptr_o(dst_ptr_o), .cnt_o(dst_cnt_o), .wrap_o(dst_wrap)
  );

  dma_chan_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk_i, .rst_ni, .en_i(ctl_en), .go_i(ctl_go), .hw_en_i(ctl_hw_en),
    .abort_en_i(ctl_abort_en), .src_stop_i(src_stop), .dst_stop_i(dst_stop),
    .trig_i, .abort_i, .gnt_i(mem_gnt_i), .rdata_i(mem_rdata_i),
    .src_wrap_i(src_wrap), .dst_wrap_i(dst_wrap),
    .state_o(st), .abort_hit_o(abort_hit), .step_o(step), .stop_hit_o(stop_hit),
    .buf_o(mem_wdata_o), .irq_src_o, .irq_dst_o, .irq_abort_o, .irq_ovr_o
  );

  assign src_space = decode_space(space_sel);

  // abort withdraws the request in its own cycle so no write completes
  assign mem_req_o   = (st != ST_IDLE) && !abort_hit;
  assign mem_we_o    = (st == ST_WR);
  assign mem_space_o = mem_we_o ? 2'(SP_DATA) : 2'(src_space);

  always_comb begin
    if (mem_we_o)                   mem_addr_o = {{PAD_W{1'b0}}, dst_ptr_o};
    else if (src_space == SP_FLASH) mem_addr_o = src_ptr_o;
    else                            mem_addr_o = {{HI_W{1'b0}}, src_ptr_o[15:0]};
  end

  assign busy_o = ctl_go || (st != ST_IDLE);
  assign xfer_o = (st == ST_WR);
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int unsigned HI_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ctl_en,
  input logic            trig_i,
  input logic            abort_i,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic            mem_gnt_i,
  input logic [1:0]      mem_space_o,
  input logic [HI_W-1:0] addr_hi,
  input logic            busy_o,
  input logic            xfer_o,
  input logic            irq_src_o,
  input logic            irq_abort_o,
  input logic            irq_ovr_o
);
  // R3
  wr_phase_buffered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> xfer_o);
  // R3
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && !mem_gnt_i && ctl_en && !abort_i |=> mem_req_o && !mem_we_o);
  // R3
  xfer_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_o) |-> $past(mem_req_o && !mem_we_o && mem_gnt_i));
  // R4
  upper_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_space_o != 2'd1 |-> addr_hi == '0);
  // R4
  wr_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_space_o == 2'd0);
  // R6
  src_irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_src_o |=> !irq_src_o);
  // R10
  ovr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ovr_o |-> $past(trig_i));
  // R11
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_abort_o |-> !busy_o && !mem_req_o);
  // R12
  en_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_en |=> !mem_req_o);
endmodule

bind dma_chan dma_chan_chk #(.HI_W(SRC_AW - 16)) i_dma_chan_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctl_en(ctl_en), .trig_i(trig_i), .abort_i(abort_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_gnt_i(mem_gnt_i),
  .mem_space_o(mem_space_o), .addr_hi(mem_addr_o[SRC_AW-1:16]),
  .busy_o(busy_o), .xfer_o(xfer_o), .irq_src_o(irq_src_o),
  .irq_abort_o(irq_abort_o), .irq_ovr_o(irq_ovr_o)
);

// File: tb/test_dma_chan.sv
`timescale 1ns/1ps
module test_dma_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        trig = 1'b0, abort = 1'b0;
  logic        mem_req, mem_we, mem_gnt;
  logic [1:0]  mem_space;
  logic [21:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [21:0] src_ptr;
  logic [15:0] dst_ptr, src_cnt, dst_cnt;
  logic busy, xfer, irq_src, irq_dst, irq_abort, irq_ovr;

  logic rd_ok = 1'b1, wr_ok = 1'b1, stall_on = 1'b0, stall_ok = 1'b1;
  int   cyc = 0;

  assign mem_gnt   = mem_req & (mem_we ? wr_ok : rd_ok) & stall_ok;
  assign mem_rdata = mem_addr[7:0] ^ {mem_space, mem_addr[21:16]};

  dma_chan i_dma_chan (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .trig_i(trig), .abort_i(abort),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_space_o(mem_space),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_gnt_i(mem_gnt), .src_ptr_o(src_ptr), .dst_ptr_o(dst_ptr),
    .src_cnt_o(src_cnt), .dst_cnt_o(dst_cnt), .busy_o(busy), .xfer_o(xfer),
    .irq_src_o(irq_src), .irq_dst_o(irq_dst), .irq_abort_o(irq_abort), .irq_ovr_o(irq_ovr)
  );

  int checks = 0, fails = 0;
  logic [15:0] log_addr [0:255];
  logic [7:0]  log_data [0:255];
  int log_n = 0, n_src = 0, n_dst = 0, n_abt = 0, n_ovr = 0;

  always @(negedge clk) begin
    if (mem_req && mem_we && mem_gnt && log_n < 256) begin
      log_addr[log_n] = mem_addr[15:0];
      log_data[log_n] = mem_wdata;
      log_n++;
    end
    if (irq_src)   n_src++;
    if (irq_dst)   n_dst++;
    if (irq_abort) n_abt++;
    if (irq_ovr)   n_ovr++;
  end

  initial forever begin
    @(negedge clk);
    cyc++;
    stall_ok = !stall_on || (cyc % 3 != 0);
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int i;
    for (i = 0; i < 3000 && busy; i++) @(negedge clk);
    chk(!busy, req, busy, 0);
  endtask

  task automatic setup(input logic [1:0] sp, input logic [1:0] sm, input logic [1:0] dm,
                       input bit ss_stop, input bit ds_stop, input logic [21:0] sa,
                       input logic [15:0] da, input logic [15:0] ssz, input logic [15:0] dsz);
    cfg_wr(3'd0, 16'h0);
    cfg_wr(3'd1, {8'h0, ds_stop, ss_stop, dm, sm, sp});
    cfg_wr(3'd2, sa[15:0]);
    cfg_wr(3'd3, {10'h0, sa[21:16]});
    cfg_wr(3'd4, da);
    cfg_wr(3'd5, ssz);
    cfg_wr(3'd6, dsz);
  endtask

  function automatic logic [7:0] exp_byte(input logic [21:0] raw, input logic [1:0] sel);
    logic [1:0]  s;
    logic [21:0] a;
    s = (sel == 2'd0) ? 2'd0 : (sel == 2'd1) ? 2'd1 : 2'd2;
    a = (s == 2'd1) ? raw : {6'h0, raw[15:0]};
    return a[7:0] ^ {s, a[21:16]};
  endfunction

  typedef struct packed {
    logic [1:0]  sp;
    logic [1:0]  sm;
    logic [1:0]  dm;
    logic        sstop;
    logic        dstop;
    logic [21:0] sa;
    logic [15:0] da;
    logic [7:0]  ss;
    logic [7:0]  ds;
    logic        stall;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd1, 2'd1, 1'b1, 1'b0, 22'h000100, 16'h2000, 8'd4, 8'd4, 1'b0},
    '{2'd1, 2'd1, 2'd0, 1'b1, 1'b0, 22'h2C0070, 16'h2100, 8'd5, 8'd1, 1'b1},
    '{2'd2, 2'd2, 2'd1, 1'b0, 1'b1, 22'h380010, 16'h2200, 8'd3, 8'd6, 1'b0},
    '{2'd3, 2'd3, 2'd2, 1'b1, 1'b1, 22'h0A0055, 16'h23FF, 8'd2, 8'd2, 1'b1},
    '{2'd0, 2'd0, 2'd1, 1'b0, 1'b1, 22'h000077, 16'h2400, 8'd1, 8'd4, 1'b1},
    '{2'd1, 2'd1, 2'd3, 1'b1, 1'b0, 22'h3FFFFE, 16'h2500, 8'd3, 8'd2, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int b, bs, bd, ba, bo;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(!busy && !xfer && !mem_req, "R1 idle outputs", {busy, xfer, mem_req}, 0);
    chk(!irq_src && !irq_dst && !irq_abort && !irq_ovr, "R1 irqs", {irq_src, irq_dst, irq_abort, irq_ovr}, 0);
    chk(src_ptr == 0 && dst_ptr == 0 && src_cnt == 0 && dst_cnt == 0, "R1 ptr/cnt", src_ptr, 0);

    // table of configurations, software start, run until a stop bit fires
    for (int v = 0; v < NV; v++) begin
      logic [21:0] sp;
      logic [15:0] dp, sc, dc;
      int n, es, ed, bad;
      logic [15:0] ea [0:63];
      logic [7:0]  ed8 [0:63];
      bit sw, dw, done;
      vec_t t;
      t = VECS[v];
      setup(t.sp, t.sm, t.dm, t.sstop, t.dstop, t.sa, t.da, {8'h0, t.ss}, {8'h0, t.ds});
      idle(1);
      chk(src_ptr == t.sa && dst_ptr == t.da && src_cnt == t.ss && dst_cnt == t.ds,
          "R2 preload", src_ptr, t.sa);
      // model
      sp = t.sa; dp = t.da; sc = {8'h0, t.ss}; dc = {8'h0, t.ds};
      n = 0; es = 0; ed = 0; done = 0;
      while (!done && n < 64) begin
        ea[n] = dp; ed8[n] = exp_byte(sp, t.sp); n++;
        sw = (sc == 1); dw = (dc == 1);
        if (sw) begin sc = {8'h0, t.ss}; sp = t.sa; es++; end
        else begin
          sc--;
          if (t.sm == 2'd1) sp = sp + 22'd1; else if (t.sm == 2'd2) sp = sp - 22'd1;
        end
        if (dw) begin dc = {8'h0, t.ds}; dp = t.da; ed++; end
        else begin
          dc--;
          if (t.dm == 2'd1) dp = dp + 16'd1; else if (t.dm == 2'd2) dp = dp - 16'd1;
        end
        done = (t.sstop && sw) || (t.dstop && dw);
      end
      b = log_n; bs = n_src; bd = n_dst;
      stall_on = t.stall;
      cfg_wr(3'd0, 16'h0003);
      wait_done("R7 stop ends operation");
      idle(4);
      stall_on = 1'b0;
      chk(log_n - b == n, "R6 write count", log_n - b, n);
      bad = 0;
      for (int k = 0; k < n && k < log_n - b; k++)
        if (log_addr[b + k] != ea[k] || log_data[b + k] != ed8[k]) bad++;
      chk(bad == 0, "R5 R4 R3 write sequence", bad, 0);
      chk(n_src - bs == es, "R6 src reload irq", n_src - bs, es);
      chk(n_dst - bd == ed, "R6 dst reload irq", n_dst - bd, ed);
      chk(src_ptr == sp && dst_ptr == dp && src_cnt == sc && dst_cnt == dc,
          "R7 final pointers", src_ptr, sp);
    end

    // R9 / R10 hardware trigger, overrun
    setup(2'd0, 2'd1, 2'd1, 1'b1, 1'b0, 22'h40, 16'h80, 16'd3, 16'd1);
    b = log_n; bs = n_src; bd = n_dst; bo = n_ovr; ba = n_abt;
    cfg_wr(3'd0, 16'h000F);
    idle(6);
    chk(log_n == b && !mem_req, "R9 no move without trigger", log_n - b, 0);
    pulse_trig(); idle(8);
    chk(log_n == b + 1, "R9 one message per trigger", log_n - b, 1);
    chk(log_addr[b] == 16'h80 && log_data[b] == 8'h40, "R9 first byte", log_data[b], 8'h40);
    wr_ok = 1'b0;
    pulse_trig(); idle(3);
    chk(xfer == 1'b1, "R3 byte held while write stalls", xfer, 1);
    pulse_trig(); idle(2);
    chk(n_ovr == bo + 1, "R10 overrun pulse", n_ovr - bo, 1);
    wr_ok = 1'b1; idle(8);
    chk(log_n == b + 2, "R10 overrun trigger dropped", log_n - b, 2);
    pulse_trig(); idle(8);
    chk(log_n == b + 3 && !busy, "R7 src stop after three", log_n - b, 3);
    chk(n_dst - bd == 3 && n_src - bs == 1, "R6 hw mode reload irqs", n_dst - bd, 3);
    @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0; idle(2);
    chk(n_abt == ba, "R7 abort enable cleared by stop", n_abt - ba, 0);

    // R11 abort drops buffered byte
    setup(2'd0, 2'd1, 2'd1, 1'b0, 1'b0, 22'h10, 16'h300, 16'd4, 16'd4);
    b = log_n; ba = n_abt;
    wr_ok = 1'b0;
    cfg_wr(3'd0, 16'h000B);
    idle(4);
    chk(xfer == 1'b1, "R3 in-progress after read", xfer, 1);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk(irq_abort == 1'b1, "R11 abort pulse", irq_abort, 1);
    chk(!busy && !xfer, "R11 idle after abort", {busy, xfer}, 0);
    wr_ok = 1'b1;
    pulse_trig(); idle(6);
    chk(log_n == b, "R11 byte discarded", log_n - b, 0);
    chk(src_ptr == 22'h10 && src_cnt == 16'd4 && dst_ptr == 16'h300, "R11 pointers untouched", src_ptr, 22'h10);
    chk(n_abt == ba + 1, "R11 single abort pulse", n_abt - ba, 1);

    // R12 enable clear reloads
    setup(2'd0, 2'd1, 2'd2, 1'b0, 1'b0, 22'h1234, 16'h0777, 16'd4, 16'd4);
    stall_on = 1'b1;
    cfg_wr(3'd0, 16'h0003);
    idle(13);
    cfg_wr(3'd0, 16'h0000);
    idle(1);
    chk(!mem_req, "R12 no request after disable", mem_req, 0);
    chk(src_ptr == 22'h1234 && dst_ptr == 16'h0777 && src_cnt == 4 && dst_cnt == 4,
        "R12 reload on disable", src_ptr, 22'h1234);
    stall_on = 1'b0;

    // R8 continuous until go cleared
    setup(2'd0, 2'd1, 2'd1, 1'b0, 1'b0, 22'h0200, 16'h0600, 16'd2, 16'd2);
    b = log_n;
    cfg_wr(3'd0, 16'h0003);
    idle(25);
    cfg_wr(3'd0, 16'h0001);
    wait_done("R8 stops after go cleared");
    chk(log_n - b >= 4 && (log_n - b) % 2 == 0, "R8 whole messages back to back", log_n - b, 4);
    chk(src_cnt == 2 && dst_cnt == 2 && src_ptr == 22'h0200, "R8 ends on message boundary", src_cnt, 2);
    b = log_n; idle(10);
    chk(log_n == b, "R8 no further message", log_n - b, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule